// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block gathers the interrupt conditions of one UART channel, keeps only the enabled ones, and places the most urgent of them in an 8-bit interrupt status value as a fixed code. It also drives an active-low interrupt pin. Seven conditions come in as level flags from the rest of the channel. The flow-control character condition comes in as pulses and is held by the block itself. One pulse marks an Xoff match and another marks a special-character match. The source of that held flag decides how it clears: a received Xon clears an Xoff match, and a status read that reports it clears a special-character match.

Software reads the status value to find which service routine to run. Each condition has its own enable bit. The two highest-numbered sources are extended sources and also need the enhanced-feature enable. The two top bits of the status value show whether FIFO mode is on.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is high and on the first cycle after it, the status reads 0x01 (with FIFO mode off) and irq_n reads 1.
- R2: The code in status[5:0] is 0x06 for line status (ie[0]), 0x0C for receive timeout (ie[1]), 0x04 for receive data ready (ie[2]), 0x02 for transmit ready (ie[3]), 0x00 for modem status (ie[4]), 0x30 for general-purpose input change (ie[5]), 0x10 for the flow-control character source (ie[6]) and 0x20 for CTS/RTS deassertion (ie[7]). The code is 0x01 when nothing is pending.
- R3: When several enabled sources are pending, only the first in the order of R2 is reported. When it clears, the next one appears.
- R4: A source whose enable bit is 0 is never reported.
- R5: The flow-control character source is captured and reported only while efr_en and ie[6] are both 1.
- R6: A flow-control character flag set by an Xoff match stays set through status reads and clears only on xon_hit.
- R7: A flag set by a special-character match clears on a status read that reported code 0x10. A read that reported a higher-priority code leaves the flag set.
- R8: The CTS/RTS source is reported only while efr_en is 1.
- R9: status[7:6] reads 2'b11 when fifo_mode is 1 and 2'b00 when it is 0.
- R10: irq_n equals status[0]. Both update on the clock edge after an input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lsr_err | input | 1 | Receiver line status error pending |
| rx_tmo | input | 1 | Receive timeout pending |
| rx_rdy | input | 1 | Receive data ready |
| tx_rdy | input | 1 | Transmit ready |
| msr_chg | input | 1 | Modem status change |
| gpio_chg | input | 1 | General-purpose input change |
| flow_chg | input | 1 | CTS# or RTS# deasserted |
| xoff_hit | input | 1 | Pulse: Xoff character matched |
| spch_hit | input | 1 | Pulse: special character matched |
| xon_hit | input | 1 | Pulse: Xon character received |
| ie | input | 8 | Per-source interrupt enables, indexed as in R2 |
| efr_en | input | 1 | Enhanced-feature enable |
| fifo_mode | input | 1 | FIFO mode flag |
| rd_isr | input | 1 | Status register read strobe |
| status | output | 8 | Interrupt status value |
| irq_n | output | 1 | Active-low interrupt output |

## Verification
The priority chain is tested with all sources raised together, then with each source dropped in turn from the top. Each step must show the next code, so a swapped level or a wrong code value shows up. Masking is tested with one enable cleared, with efr_en cleared, and with all enables cleared. These tell the per-source gate apart from the extended-source gate. The held flag is tested with an Xoff match and with a special-character match. Each gets a read and an Xon in turn, and one read happens while a higher-priority line status code hides the flag. This tells the two clear rules apart and shows that a read only clears the source it reported.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC  = 8;
  localparam int CODEW = 6;
  localparam logic [CODEW-1:0] CODE_IDLE = 6'h01;
  localparam int XSC_IDX  = 6;
  localparam int EXT_BASE = 6;

  typedef enum logic {CAUSE_XOFF, CAUSE_SPCH} xsc_cause_t;

  function automatic logic [CODEW-1:0] src_code(input int idx);
    case (idx)
      0: src_code = 6'h06;
      1: src_code = 6'h0C;
      2: src_code = 6'h04;
      3: src_code = 6'h02;
      4: src_code = 6'h00;
      5: src_code = 6'h30;
      6: src_code = 6'h10;
      7: src_code = 6'h20;
      default: src_code = CODE_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_gate.sv
module uart_irq_gate
  import uart_irq_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int XB = EXT_BASE
) (
  input  logic [N-1:0] raw,
  input  logic [N-1:0] ie,
  input  logic         efr_en,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_src
    if (i >= XB) begin : g_ext
      assign pend[i] = raw[i] & ie[i] & efr_en;
    end else begin : g_std
      assign pend[i] = raw[i] & ie[i];
    end
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0]       pend,
  output logic [CODEW-1:0]   code
);
  always_comb begin
    code = CODE_IDLE;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) code = src_code(i);
    end
  end
endmodule

// File: rtl/uart_irq_xsc.sv
module uart_irq_xsc
  import uart_irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic xoff_hit,
  input  logic spch_hit,
  input  logic xon_hit,
  input  logic rd_rep,
  output logic flag
);
  xsc_cause_t cause_q;
  logic       flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      cause_q <= CAUSE_XOFF;
    end else if (arm && (xoff_hit || spch_hit)) begin
      flag_q  <= 1'b1;
      cause_q <= xoff_hit ? CAUSE_XOFF : CAUSE_SPCH;
    end else if (flag_q) begin
      if ((cause_q == CAUSE_XOFF && xon_hit) ||
          (cause_q == CAUSE_SPCH && rd_rep))
        flag_q <= 1'b0;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lsr_err,
  input  logic         rx_tmo,
  input  logic         rx_rdy,
  input  logic         tx_rdy,
  input  logic         msr_chg,
  input  logic         gpio_chg,
  input  logic         flow_chg,
  input  logic         xoff_hit,
  input  logic         spch_hit,
  input  logic         xon_hit,
  input  logic [N-1:0] ie,
  input  logic         efr_en,
  input  logic         fifo_mode,
  input  logic         rd_isr,
  output logic [7:0]   status,
  output logic         irq_n
);
  logic [N-1:0]     raw, pend;
  logic [CODEW-1:0] code;
  logic             xsc_flag, rd_rep;
  logic [7:0]       status_q;
  logic             irq_n_q;

  assign rd_rep = rd_isr && (status_q[CODEW-1:0] == src_code(XSC_IDX));

  uart_irq_xsc u_xsc (
    .clk(clk), .rst(rst), .arm(efr_en & ie[XSC_IDX]),
    .xoff_hit(xoff_hit), .spch_hit(spch_hit), .xon_hit(xon_hit),
    .rd_rep(rd_rep), .flag(xsc_flag)
  );

  assign raw = {flow_chg, xsc_flag, gpio_chg, msr_chg,
                tx_rdy, rx_rdy, rx_tmo, lsr_err};

  uart_irq_gate #(.N(N)) u_gate (
    .raw(raw), .ie(ie), .efr_en(efr_en), .pend(pend)
  );

  uart_irq_prio #(.N(N)) u_prio (.pend(pend), .code(code));

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= {2'b00, CODE_IDLE};
      irq_n_q  <= 1'b1;
    end else begin
      status_q <= {{2{fifo_mode}}, code};
      irq_n_q  <= (code != CODE_IDLE) ? 1'b0 : 1'b1;
    end
  end

  assign status = status_q;
  assign irq_n  = irq_n_q;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst,
  input logic       lsr_err,
  input logic [7:0] ie,
  input logic       efr_en,
  input logic       fifo_mode,
  input logic [7:0] status,
  input logic       irq_n
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (status == 8'h01 && irq_n));

  assert_lsr_first_R3: assert property (@(posedge clk) disable iff (rst)
    $past(lsr_err & ie[0] & !rst) |-> status[5:0] == 6'h06);

  assert_ext_gate_R5: assert property (@(posedge clk) disable iff (rst)
    $past(!(efr_en & ie[6]) & !rst) |-> status[5:0] != 6'h10);

  assert_flow_gate_R8: assert property (@(posedge clk) disable iff (rst)
    $past(!efr_en & !rst) |-> status[5:0] != 6'h20);

  assert_fifo_bits_R9: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> status[7:6] == {2{$past(fifo_mode)}});

  assert_pin_match_R10: assert property (@(posedge clk) disable iff (rst)
    irq_n == status[0]);
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk(clk), .rst(rst), .lsr_err(lsr_err), .ie(ie), .efr_en(efr_en),
  .fifo_mode(fifo_mode), .status(status), .irq_n(irq_n)
);

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  // vector: ie[24:17] efr[16] fifo[15] lvl[14:8] exp[7:0]
  // lvl bits: 0 lsr,1 tmo,2 rdy,3 tx,4 msr,5 gpio,6 flow
  localparam logic [24:0] VEC [NV] = '{
    {8'hFF, 1'b1, 1'b0, 7'h7F, 8'h06},  // R2 R3
    {8'hFF, 1'b1, 1'b0, 7'h7E, 8'h0C},
    {8'hFF, 1'b1, 1'b0, 7'h7C, 8'h04},
    {8'hFF, 1'b1, 1'b0, 7'h78, 8'h02},
    {8'hFF, 1'b1, 1'b0, 7'h70, 8'h00},
    {8'hFF, 1'b1, 1'b0, 7'h60, 8'h30},
    {8'hFF, 1'b1, 1'b0, 7'h40, 8'h20},
    {8'hFF, 1'b1, 1'b0, 7'h00, 8'h01},
    {8'hFF, 1'b1, 1'b1, 7'h08, 8'hC2},  // R9
    {8'hFE, 1'b1, 1'b0, 7'h03, 8'h0C},  // R4
    {8'hFF, 1'b0, 1'b0, 7'h40, 8'h01},  // R8
    {8'h00, 1'b1, 1'b0, 7'h7F, 8'h01}   // R4
  };

  logic clk = 0, rst = 1;
  logic lsr_err = 0, rx_tmo = 0, rx_rdy = 0, tx_rdy = 0, msr_chg = 0;
  logic gpio_chg = 0, flow_chg = 0, xoff_hit = 0, spch_hit = 0, xon_hit = 0;
  logic [7:0] ie = 8'hFF;
  logic efr_en = 1, fifo_mode = 0, rd_isr = 0;
  logic [7:0] status;
  logic irq_n;
  int applied = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ident uut (
    .clk(clk), .rst(rst), .lsr_err(lsr_err), .rx_tmo(rx_tmo), .rx_rdy(rx_rdy),
    .tx_rdy(tx_rdy), .msr_chg(msr_chg), .gpio_chg(gpio_chg), .flow_chg(flow_chg),
    .xoff_hit(xoff_hit), .spch_hit(spch_hit), .xon_hit(xon_hit), .ie(ie),
    .efr_en(efr_en), .fifo_mode(fifo_mode), .rd_isr(rd_isr),
    .status(status), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [7:0] exp);
    applied++;
    if (status !== exp || irq_n !== exp[0]) begin
      bad++;
      $display("FAIL %s status=%02h irq_n=%b expected status=%02h irq_n=%b",
               req, status, irq_n, exp, exp[0]);
    end
  endtask

  task automatic set_lvl(input logic [6:0] l);
    {flow_chg, gpio_chg, msr_chg, tx_rdy, rx_rdy, rx_tmo, lsr_err} = l;
  endtask

  task automatic pulse_xoff();
    xoff_hit = 1; @(negedge clk); xoff_hit = 0; @(negedge clk);
  endtask
  task automatic pulse_spch();
    spch_hit = 1; @(negedge clk); spch_hit = 0; @(negedge clk);
  endtask
  task automatic pulse_xon();
    xon_hit = 1; @(negedge clk); xon_hit = 0; @(negedge clk);
  endtask
  task automatic pulse_rd();
    rd_isr = 1; @(negedge clk); rd_isr = 0; @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    check("R1", 8'h01);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1", 8'h01);

    for (int i = 0; i < NV; i++) begin
      {ie, efr_en, fifo_mode} = VEC[i][24:15];
      set_lvl(VEC[i][14:8]);
      @(negedge clk);
      check("R2 R3 R4 R8 R9 R10 vector", VEC[i][7:0]);
    end
    ie = 8'hFF; efr_en = 1; fifo_mode = 0; set_lvl(7'h00);
    @(negedge clk);

    // R6: Xoff-caused flag survives reads, cleared by Xon
    pulse_xoff();
    check("R6 set", 8'h10);
    pulse_rd(); @(negedge clk);
    check("R6 read ignored", 8'h10);
    pulse_xon();
    check("R6 xon clear", 8'h01);

    // R7: special-char flag cleared by read of 0x10
    pulse_spch();
    check("R7 set", 8'h10);
    pulse_rd();
    check("R7 read clear", 8'h01);

    // R7: read reporting a higher code leaves the flag
    pulse_spch();
    lsr_err = 1; @(negedge clk);
    check("R7 masked", 8'h06);
    pulse_rd();
    lsr_err = 0; @(negedge clk);
    check("R7 kept after masked read", 8'h10);
    pulse_rd();
    check("R7 later clear", 8'h01);

    // R5: no capture while efr_en is 0 or ie[6] is 0
    efr_en = 0; pulse_spch(); efr_en = 1; @(negedge clk);
    check("R5 efr gate", 8'h01);
    ie[6] = 0; pulse_xoff(); ie[6] = 1; @(negedge clk);
    check("R5 ie gate", 8'h01);

    // R10: one-edge latency
    tx_rdy = 1; #1;
    check("R10 not yet", 8'h01);
    @(negedge clk);
    check("R10 after edge", 8'h02);
    tx_rdy = 0;

    // R1: reset while sources active
    lsr_err = 1; fifo_mode = 1; rst = 1; @(negedge clk);
    check("R1 in reset", 8'h01);
    rst = 0; lsr_err = 0; fifo_mode = 0;
    done = 1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      applied++; bad++;
      $display("FAIL watchdog expired");
    end
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule